// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces, one beat per clock, the column addresses of a single read or write burst to a synchronous DRAM. A controller pulses `start_i` with a start column, a length code and an ordering select. From the next cycle on, the block presents one column per cycle with `valid_o` high. It raises `last_o` on the final beat of a fixed-length burst.

The ordering is either sequential, which counts upward inside an aligned block of the burst length, or interleaved, which flips the low column bits by the beat number. A full-page burst counts through all columns of the row, wraps past the top, and keeps going until it is stopped. A terminate strobe stops any burst. A fresh start strobe replaces the running burst on any cycle, with no alignment rule between the two starts. Interleaved ordering cannot be combined with full page. If that combination is requested, the block runs a sequential full-page burst and flags the request as illegal.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `valid_o`, `last_o` and `mode_err_o` are low after that edge and stay low until a start is taken.
- R2: A start sampled at an edge makes `valid_o` high after that edge, with `col_o` equal to the sampled start column. The length code is decoded as 0 for 1 beat, 1 for 2 beats, 2 for 4 beats and 3 for 8 beats. Any code with bit 2 set means full page.
- R3: In sequential ordering with length L, beat k has its low log2(L) bits equal to (start + k) mod L. All higher bits equal those of the start column.
- R4: In interleaved ordering with length L, beat k has its low log2(L) bits equal to the start column's low bits XOR k. All higher bits equal those of the start column.
- R5: A fixed-length burst of length L gives exactly L consecutive valid beats. `last_o` is high on beat L-1 only, and `valid_o` is low in the cycle after it.
- R6: With length 1, a single valid beat is produced, and `last_o` is high in that same cycle.
- R7: A full-page burst steps the column by one each cycle and wraps from 511 to 0. It never asserts `last_o` and runs until a terminate or a new start.
- R8: A terminate sampled at an edge, with no start at that same edge, makes `valid_o` low after the edge. When start and terminate arrive together, the start is taken.
- R9: A start sampled during a running burst, on any beat, restarts from the new column with the new length and ordering, at beat 0.
- R10: Interleaved ordering together with a full-page code yields a sequential full-page burst. `mode_err_o` is high on every beat of that burst and low whenever `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a new burst (also replaces a running one) |
| term_i | input | 1 | Stop the running burst |
| start_col_i | input | COL_W | Start column for the burst |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 selects interleaved ordering, 0 sequential |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |
| mode_err_o | output | 1 | Current burst came from an illegal interleave and full-page request |

## Verification
A corrupted beat counter or latched length mask shows up within one beat as a wrong column. It can also appear as `last_o` on the wrong beat, which cuts the burst short or lets it run over by at least one cycle. A stale base column or ordering flag after a restart is visible on the very first beat following the new start. A wrong wrap in full page appears at the 511-to-0 crossing. For these reasons the bench compares every beat of every burst, rather than only the first and last.

// File: rtl/bcg_pkg.sv
// Package: shared widths and the per-burst configuration record.
// Assumes a length code of three bits, bit 2 selecting full page.
package bcg_pkg;
    localparam int LEN_W = 3;

    typedef struct packed {
        logic full;        // burst runs until stopped
        logic interleave;  // effective ordering (never set with full)
        logic err;         // illegal interleave + full page request
    } burst_cfg_t;
endpackage

// File: rtl/bcg_len_decode.sv
// Length decoder: turns the length code and ordering select into the
// low-bit mask of the burst and the effective configuration.
// Assumes COL_W >= 4 so an 8-beat mask fits in the column.
module bcg_len_decode #(
    parameter int COL_W = 9
) (
    input  logic [bcg_pkg::LEN_W-1:0] len_code_i,
    input  logic                      interleave_i,
    output logic [COL_W-1:0]          mask_o,
    output bcg_pkg::burst_cfg_t       cfg_o
);
    logic [3:0] short_mask;

    // Build the mask: all ones for full page, else (2^code)-1.
    always_comb begin
        short_mask = 4'((5'd1 << len_code_i[1:0]) - 5'd1);
        if (len_code_i[2]) begin
            mask_o = {COL_W{1'b1}};
        end else begin
            mask_o = {{(COL_W-4){1'b0}}, short_mask};
        end
    end

    // Resolve ordering; full page forces sequential and flags a conflict.
    always_comb begin
        cfg_o.full       = len_code_i[2];
        cfg_o.interleave = interleave_i & ~len_code_i[2];
        cfg_o.err        = interleave_i &  len_code_i[2];
    end
endmodule

// File: rtl/bcg_beat_ctrl.sv
// Beat controller: holds the active flag, the beat counter and the
// latched mask. Start beats terminate; terminate beats counting.
// Assumes the mask is a contiguous run of low ones.
module bcg_beat_ctrl #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] mask_d,
    input  logic             full_d,
    output logic             active_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [COL_W-1:0] mask_o,
    output logic             last_o
);
    logic             active_q;
    logic             full_q;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] mask_q;
    logic             at_end;

    // Final beat of a fixed-length burst.
    always_comb begin
        at_end = active_q & ~full_q & (cnt_q == mask_q);
    end

    // Advance, restart or stop the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            full_q   <= 1'b0;
            cnt_q    <= '0;
            mask_q   <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            full_q   <= full_d;
            cnt_q    <= '0;
            mask_q   <= mask_d;
        end else if (term_i) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (at_end) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign cnt_o    = cnt_q;
    assign mask_o   = mask_q;
    assign last_o   = at_end;
endmodule

// File: rtl/bcg_order.sv
// Ordering unit: forms the column of the current beat from the base
// column, the beat count and the mask. Bits outside the mask keep the
// base value; bits inside take the sum (sequential) or XOR (interleave).
module bcg_order #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             interleave_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;

    // Full-width sum; only its masked low bits are used.
    always_comb begin
        sum = base_i + cnt_i;
    end

    // Per-bit selection between base, sum and XOR.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!mask_i[b]) begin
                col_o[b] = base_i[b];
            end else if (interleave_i) begin
                col_o[b] = base_i[b] ^ cnt_i[b];
            end else begin
                col_o[b] = sum[b];
            end
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
// Top: burst column address generator. Latches the start column and
// the resolved configuration on a start, and drives one column per
// cycle. Assumes start and terminate are single-cycle strobes.
module burst_col_gen #(
    parameter int COL_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      term_i,
    input  logic [COL_W-1:0]          start_col_i,
    input  logic [bcg_pkg::LEN_W-1:0] len_code_i,
    input  logic                      interleave_i,
    output logic [COL_W-1:0]          col_o,
    output logic                      valid_o,
    output logic                      last_o,
    output logic                      mode_err_o
);
    logic [COL_W-1:0]    mask_d;
    bcg_pkg::burst_cfg_t cfg_d;
    bcg_pkg::burst_cfg_t cfg_q;
    logic [COL_W-1:0]    base_q;
    logic                active;
    logic [COL_W-1:0]    cnt;
    logic [COL_W-1:0]    mask_q;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code_i   (len_code_i),
        .interleave_i (interleave_i),
        .mask_o       (mask_d),
        .cfg_o        (cfg_d)
    );

    // Capture the base column and configuration at each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cfg_q  <= '0;
        end else if (start_i) begin
            base_q <= start_col_i;
            cfg_q  <= cfg_d;
        end
    end

    bcg_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .term_i   (term_i),
        .mask_d   (mask_d),
        .full_d   (cfg_d.full),
        .active_o (active),
        .cnt_o    (cnt),
        .mask_o   (mask_q),
        .last_o   (last_o)
    );

    bcg_order #(.COL_W(COL_W)) u_ord (
        .base_i       (base_q),
        .cnt_i        (cnt),
        .mask_i       (mask_q),
        .interleave_i (cfg_q.interleave),
        .col_o        (col_o)
    );

    assign valid_o    = active;
    assign mode_err_o = active & cfg_q.err;
endmodule

// File: rtl/bcg_checker.sv
// Checker: port-level properties of burst_col_gen. Keeps its own copy
// of the requested mode at each start to qualify the stepping checks.
module bcg_checker #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             term_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       len_code_i,
    input logic             interleave_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             mode_err_o
);
    logic full_req_q;

    // Remember whether the running burst was requested as full page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_req_q <= 1'b0;
        end else if (start_i) begin
            full_req_q <= len_code_i[2];
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !last_o && !mode_err_o));

    p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && last_o && !start_i) |=> !valid_o);

    p_last_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    p_full_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && full_req_q && !start_i && !term_i)
        |=> (valid_o && !last_o && col_o == COL_W'($past(col_o) + 1'b1)));

    p_term_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (term_i && !start_i) |=> !valid_o);

    p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && interleave_i && len_code_i[2]) |=> mode_err_o);

    p_err_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> valid_o);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_bcg_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .term_i       (term_i),
    .start_col_i  (start_col_i),
    .len_code_i   (len_code_i),
    .interleave_i (interleave_i),
    .col_o        (col_o),
    .valid_o      (valid_o),
    .last_o       (last_o),
    .mode_err_o   (mode_err_o)
);

// File: tb/burst_col_gen_bench.sv
// Directed bench: one task per scenario, each checking its own beats.
// Inputs change and outputs are sampled just after the falling edge.
module burst_col_gen_bench;
    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             interleave_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;
    logic             mode_err_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .term_i(term_i),
        .start_col_i(start_col_i), .len_code_i(len_code_i),
        .interleave_i(interleave_i), .col_o(col_o), .valid_o(valid_o),
        .last_o(last_o), .mode_err_o(mode_err_o)
    );

    // Expected column of beat k, taken from R2, R3, R4, R7 and R10.
    function automatic int exp_col(int s, int code, bit il, int k);
        int m;
        if (code >= 4) return (s + k) % 512;
        m = (1 << code) - 1;
        if (il) return (s & ~m) | ((s ^ k) & m);
        return (s & ~m) | ((s + k) & m);
    endfunction

    task automatic check(string req, bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue a start; returns in the cycle showing beat 0.
    task automatic pulse_start(int col, int code, bit il);
        start_i = 1'b1;
        start_col_i = COL_W'(col);
        len_code_i = 3'(code);
        interleave_i = il;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Check n beats starting at beat 0; returns one cycle after the last checked.
    task automatic expect_beats(string req, int col, int code, bit il, int n);
        int len = (code >= 4) ? 0 : (1 << code);
        for (int k = 0; k < n; k++) begin
            int ec = exp_col(col, code, il, k);
            bit el = (len != 0) && (k == len - 1);
            check(req, valid_o == 1'b1, "valid", int'(valid_o), 1);
            check(req, int'(col_o) == ec, "col", int'(col_o), ec);
            check(req, last_o == el, "last", int'(last_o), int'(el));
            check("R10", mode_err_o == (il && code >= 4), "err",
                  int'(mode_err_o), int'(il && code >= 4));
            @(negedge clk);
        end
    endtask

    task automatic expect_idle(string req);
        check(req, valid_o == 1'b0, "valid idle", int'(valid_o), 0);
        check(req, last_o == 1'b0, "last idle", int'(last_o), 0);
        check(req, mode_err_o == 1'b0, "err idle", int'(mode_err_o), 0);
    endtask

    task automatic t_reset;   // R1
        repeat (3) @(negedge clk);
        expect_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        expect_idle("R1");
    endtask

    task automatic t_fixed(int col, int code, bit il, string req);  // R2-R5
        pulse_start(col, code, il);
        expect_beats(req, col, code, il, 1 << code);
        expect_idle("R5");
    endtask

    task automatic t_single;   // R6
        pulse_start(9'h0AB, 0, 1'b0);
        expect_beats("R6", 9'h0AB, 0, 1'b0, 1);
        expect_idle("R6");
    endtask

    task automatic t_full_wrap;   // R7, R8
        pulse_start(9'h1FC, 7, 1'b0);
        expect_beats("R7", 9'h1FC, 7, 1'b0, 8);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        expect_idle("R8");
    endtask

    task automatic t_restart;   // R9
        pulse_start(9'h010, 3, 1'b0);
        expect_beats("R9", 9'h010, 3, 1'b0, 3);
        pulse_start(9'h047, 2, 1'b1);
        expect_beats("R9", 9'h047, 2, 1'b1, 1);
        pulse_start(9'h123, 1, 1'b0);   // start on the very next beat
        expect_beats("R9", 9'h123, 1, 1'b0, 2);
        expect_idle("R9");
    endtask

    task automatic t_start_term_same;   // R8
        pulse_start(9'h0F0, 2, 1'b0);
        expect_beats("R8", 9'h0F0, 2, 1'b0, 1);
        term_i = 1'b1;
        pulse_start(9'h055, 2, 1'b1);
        term_i = 1'b0;
        expect_beats("R8", 9'h055, 2, 1'b1, 4);
        expect_idle("R8");
    endtask

    task automatic t_illegal;   // R10
        pulse_start(9'h1FE, 5, 1'b1);
        expect_beats("R10", 9'h1FE, 5, 1'b1, 4);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        expect_idle("R10");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fixed(9'h005, 3, 1'b0, "R3");
        t_fixed(9'h1A5, 2, 1'b0, "R3");
        t_fixed(9'h0D3, 3, 1'b1, "R4");
        t_fixed(9'h0E6, 2, 1'b1, "R4");
        t_fixed(9'h131, 1, 1'b1, "R4");
        t_fixed(9'h0FF, 1, 1'b0, "R2");
        t_single();
        t_full_wrap();
        t_restart();
        t_start_term_same();
        t_illegal();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule